// File: doc/BRIEF.md
# DDR Read Capture Delay Calibrator

This block trains the read-capture path of a DDR memory interface. A programmable input delay sits on the strobe and on the data lines, followed by a 1:4 deserializer. The calibrator moves both delays together, one tap per step. After each step it waits for the delay line to settle. It then requests a read of a known four-beat training burst and compares the deserialized word against the expected beat order.

If the strobe path adds extra delay, the deserializer delivers the same four beats with their order rotated by two positions. The block treats that word as a failure, the same as any partial match. It keeps stepping until a fixed number of reads in a row, taken at one tap setting, return the exact training order. It then stops and raises done. If the last tap is reached without a stable match, it raises fail instead.

The block sits between the memory controller's read path and the delay-line controls. The controller issues one training read for each request pulse and returns the captured word with a one-cycle valid. The chosen tap setting stays on an output for debug.

Top module: `rdcal_ctrl`

## Requirements
- R1: After reset the block is idle. `dly_rst_o` is held high, `dly_inc_o`, `rd_req_o`, `done_o` and `fail_o` are low, and `tap_o` is 0.
- R2: `start_i` is accepted only while idle, done or failed. Accepting it clears done and fail and produces exactly one cycle of `dly_rst_o` (outside idle), which returns `tap_o` to 0. `start_i` pulses during a search have no effect. `dly_rst_o` and `dly_inc_o` are never high together.
- R3: After the cycle in which `dly_rst_o` (from a start) or `dly_inc_o` is high, the block waits exactly SETTLE_CYC cycles. `rd_req_o` then rises SETTLE_CYC+1 cycles after that pulse cycle.
- R4: `rd_req_o` is a one-cycle pulse and only one read is outstanding at a time. After a request, the block waits any number of cycles for `rd_valid_i`. `rd_valid_i` seen while no read is outstanding is ignored.
- R5: Beat k of the captured word occupies bits [k*BEAT_W +: BEAT_W]. Beat 0 (lowest bits) is the first beat of the burst. A read matches only if all four beats equal the TRAIN_WORD beats in the same positions. The two-beat rotation (D2,D3,D0,D1), a word with three of four beats correct, and any other word all count as mismatches.
- R6: A mismatch below the last tap gives one single-cycle `dly_inc_o` pulse, which steps strobe and data delays together. `tap_o` rises by exactly 1 in the following cycle.
- R7: PASS_RUNS consecutive matching reads at one tap raise `done_o`. A mismatch clears the run count and moves on to the next tap, so the final tap is the first tap that produced PASS_RUNS matches in a row.
- R8: A mismatch at tap NUM_TAPS-1 raises `fail_o` with no further increment. `tap_o` then reads NUM_TAPS-1, after NUM_TAPS-1 increment pulses in total.
- R9: `done_o` and `fail_o` are never high together and stay high until the next accepted start. While either is high, `tap_o` holds its value and `dly_inc_o`, `dly_rst_o` and `rd_req_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Begin (or restart) calibration |
| rd_req_o | output | 1 | One-cycle request for a training-burst read |
| rd_valid_i | input | 1 | Captured word is valid this cycle |
| rd_word_i | input | 4*BEAT_W | Deserialized burst, beat 0 in the lowest bits |
| dly_rst_o | output | 1 | Return strobe and data delays to tap 0 |
| dly_inc_o | output | 1 | Step strobe and data delays up by one tap |
| done_o | output | 1 | Calibration succeeded (sticky) |
| fail_o | output | 1 | Tap range exhausted without a stable match (sticky) |
| tap_o | output | $clog2(NUM_TAPS) | Current or final tap setting |

## Verification
The bench builds the block with 4-bit beats, 8 taps, a 3-cycle settle time and 2 required consecutive matches. With only 8 taps, every start position of a passing tap window can be swept, including a window that never appears and one that starts on the last tap. Each position is combined with several window widths, a one-read glitch at the first good tap, read latencies of 1 to 3 cycles, stray valids, and each kind of bad word (rotated, three-beat partial, all zero). The final tap, the read count and the increment count are predicted arithmetically for every combination.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;

  // beats per deserialized burst (1:4 input deserializer)
  localparam int unsigned BEATS = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RSTDLY,
    ST_READ,
    ST_WAIT,
    ST_CMP,
    ST_INC,
    ST_SETTLE,
    ST_DONE,
    ST_FAIL
  } cal_state_e;

endpackage

// File: rtl/rdcal_beat_cmp.sv
module rdcal_beat_cmp
  import rdcal_pkg::*;
#(
  parameter int unsigned          BEAT_W     = 8,
  parameter logic [4*BEAT_W-1:0]  TRAIN_WORD = '0
) (
  input  logic [BEATS*BEAT_W-1:0] word_i,
  output logic [BEATS-1:0]        beat_eq_o,
  output logic                    match_o
);

  // one equality slice per beat position; rotation leaves slices unequal
  for (genvar k = 0; k < BEATS; k++) begin : g_beat
    assign beat_eq_o[k] = (word_i[k*BEAT_W +: BEAT_W] == TRAIN_WORD[k*BEAT_W +: BEAT_W]);
  end

  // every beat must be in place; a partial hit does not count
  assign match_o = &beat_eq_o;

endmodule

// File: rtl/rdcal_settle_tmr.sv
module rdcal_settle_tmr #(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic en_i,
  output logic expired_o
);

  localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired_o = (cnt_q == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = RELOAD;
    end else if (en_i && !expired_o) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rdcal_fsm.sv
module rdcal_fsm
  import rdcal_pkg::*;
#(
  parameter int unsigned NUM_TAPS  = 64,
  parameter int unsigned PASS_RUNS = 4,
  parameter int unsigned TAP_W     = $clog2(NUM_TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rd_valid_i,
  input  logic             match_i,
  input  logic             settle_done_i,
  output logic             settle_load_o,
  output logic             settle_en_o,
  output logic             rd_req_o,
  output logic             dly_rst_o,
  output logic             dly_inc_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [TAP_W-1:0] tap_o
);

  localparam int unsigned PASS_W = $clog2(PASS_RUNS + 1);
  localparam logic [TAP_W-1:0]  TAP_LAST  = TAP_W'(NUM_TAPS - 1);
  localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(PASS_RUNS - 1);

  cal_state_e        state_q, state_d;
  logic [TAP_W-1:0]  tap_q, tap_d;
  logic              tap_en;
  logic [PASS_W-1:0] pass_q, pass_d;
  logic              pass_en;
  logic              hit_q, hit_d;
  logic              hit_en;

  // next-state and datapath enables
  always_comb begin
    state_d = state_q;
    tap_d   = tap_q;
    tap_en  = 1'b0;
    pass_d  = pass_q;
    pass_en = 1'b0;
    hit_d   = hit_q;
    hit_en  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start_i) state_d = ST_RSTDLY;
      end
      ST_RSTDLY: begin
        tap_d   = '0;
        tap_en  = 1'b1;
        pass_d  = '0;
        pass_en = 1'b1;
        state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settle_done_i) state_d = ST_READ;
      end
      ST_READ: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rd_valid_i) begin
          hit_d   = match_i;
          hit_en  = 1'b1;
          state_d = ST_CMP;
        end
      end
      ST_CMP: begin
        pass_en = 1'b1;
        if (hit_q) begin
          if (pass_q == PASS_LAST) begin
            pass_d  = '0;
            state_d = ST_DONE;
          end else begin
            pass_d  = pass_q + 1'b1;
            state_d = ST_READ;
          end
        end else begin
          pass_d = '0;
          if (tap_q == TAP_LAST) state_d = ST_FAIL;
          else                   state_d = ST_INC;
        end
      end
      ST_INC: begin
        tap_d   = tap_q + 1'b1;
        tap_en  = 1'b1;
        state_d = ST_SETTLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= '0;
    end else if (tap_en) begin
      tap_q <= tap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= '0;
    end else if (pass_en) begin
      pass_q <= pass_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else if (hit_en) begin
      hit_q <= hit_d;
    end
  end

  // Moore outputs decoded from the state register
  assign settle_load_o = (state_q == ST_RSTDLY) || (state_q == ST_INC);
  assign settle_en_o   = (state_q == ST_SETTLE);
  assign rd_req_o      = (state_q == ST_READ);
  assign dly_rst_o     = (state_q == ST_IDLE) || (state_q == ST_RSTDLY);
  assign dly_inc_o     = (state_q == ST_INC);
  assign done_o        = (state_q == ST_DONE);
  assign fail_o        = (state_q == ST_FAIL);
  assign tap_o         = tap_q;

endmodule

// File: rtl/rdcal_ctrl.sv
module rdcal_ctrl
  import rdcal_pkg::*;
#(
  parameter int unsigned         BEAT_W     = 8,
  parameter logic [4*BEAT_W-1:0] TRAIN_WORD = 32'hE14B_D278,
  parameter int unsigned         NUM_TAPS   = 64,
  parameter int unsigned         SETTLE_CYC = 8,
  parameter int unsigned         PASS_RUNS  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  output logic                        rd_req_o,
  input  logic                        rd_valid_i,
  input  logic [4*BEAT_W-1:0]         rd_word_i,
  output logic                        dly_rst_o,
  output logic                        dly_inc_o,
  output logic                        done_o,
  output logic                        fail_o,
  output logic [$clog2(NUM_TAPS)-1:0] tap_o
);

  localparam int unsigned TAP_W = $clog2(NUM_TAPS);

  logic [BEATS-1:0] beat_eq;
  logic             word_match;
  logic             settle_load;
  logic             settle_en;
  logic             settle_done;

  rdcal_beat_cmp #(
    .BEAT_W     (BEAT_W),
    .TRAIN_WORD (TRAIN_WORD)
  ) cmp_i (
    .word_i    (rd_word_i),
    .beat_eq_o (beat_eq),
    .match_o   (word_match)
  );

  rdcal_settle_tmr #(
    .SETTLE_CYC (SETTLE_CYC)
  ) tmr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (settle_load),
    .en_i      (settle_en),
    .expired_o (settle_done)
  );

  rdcal_fsm #(
    .NUM_TAPS  (NUM_TAPS),
    .PASS_RUNS (PASS_RUNS),
    .TAP_W     (TAP_W)
  ) fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .rd_valid_i    (rd_valid_i),
    .match_i       (word_match),
    .settle_done_i (settle_done),
    .settle_load_o (settle_load),
    .settle_en_o   (settle_en),
    .rd_req_o      (rd_req_o),
    .dly_rst_o     (dly_rst_o),
    .dly_inc_o     (dly_inc_o),
    .done_o        (done_o),
    .fail_o        (fail_o),
    .tap_o         (tap_o)
  );

endmodule

// File: rtl/rdcal_chk.sv
module rdcal_chk #(
  parameter int unsigned NUM_TAPS = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start_i,
  input logic                        rd_req_o,
  input logic                        dly_rst_o,
  input logic                        dly_inc_o,
  input logic                        done_o,
  input logic                        fail_o,
  input logic [$clog2(NUM_TAPS)-1:0] tap_o
);

  localparam int unsigned TAP_W = $clog2(NUM_TAPS);

  // R4
  rd_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);

  // R6
  inc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_inc_o |=> !dly_inc_o);

  // R6
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_inc_o |=> (tap_o == TAP_W'($past(tap_o) + 1'b1)));

  // R2
  rst_inc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dly_rst_o && dly_inc_o));

  // R9
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(tap_o)));

  // R9
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> (fail_o && $stable(tap_o)));

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |-> !(dly_inc_o || dly_rst_o || rd_req_o));

  // R8
  fail_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (tap_o == TAP_W'(NUM_TAPS - 1)));

endmodule

bind rdcal_ctrl rdcal_chk #(.NUM_TAPS(NUM_TAPS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .rd_req_o  (rd_req_o),
  .dly_rst_o (dly_rst_o),
  .dly_inc_o (dly_inc_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .tap_o     (tap_o)
);

// File: tb/rdcal_ctrl_tb_top.sv
`timescale 1ns/1ps
module rdcal_ctrl_tb_top;

  localparam int BW   = 4;
  localparam int NT   = 8;
  localparam int SC   = 3;
  localparam int PR   = 2;
  localparam int TW   = $clog2(NT);
  localparam logic [4*BW-1:0] TW_WORD = 16'hC5A3; // D0=3 D1=A D2=5 D3=C
  localparam logic [4*BW-1:0] ROT_W   = 16'hA3C5; // D2,D3,D0,D1 in beats 0..3
  localparam logic [4*BW-1:0] PART_W  = 16'hCAA3; // beat 2 wrong, rest right

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          rd_req;
  logic          rd_valid;
  logic [4*BW-1:0] rd_word;
  logic          dly_rst;
  logic          dly_inc;
  logic          done;
  logic          fail;
  logic [TW-1:0] tap;

  rdcal_ctrl #(
    .BEAT_W(BW), .TRAIN_WORD(TW_WORD), .NUM_TAPS(NT),
    .SETTLE_CYC(SC), .PASS_RUNS(PR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rd_req_o(rd_req),
    .rd_valid_i(rd_valid), .rd_word_i(rd_word), .dly_rst_o(dly_rst),
    .dly_inc_o(dly_inc), .done_o(done), .fail_o(fail), .tap_o(tap)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  int n_chk  = 0;
  int n_fail = 0;

  // environment model state
  int lo_g, hi_g, lat_g, kind_g;
  bit gl_g, spur_g;
  int cyc, mtap, nread, lcnt, last_pulse;
  bit pending, armed;
  int rst_seen, inc_seen, req_seen, gap_seen, gap_bad;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  function automatic bit good_rd(input int t, input int idx, input int lo, input int hi, input bit gl);
    return (t >= lo) && (t <= hi) && !(gl && t == lo && idx == 1);
  endfunction

  function automatic logic [4*BW-1:0] bad_word(input int kind);
    case (kind)
      0:       return ROT_W;
      1:       return PART_W;
      default: return '0;
    endcase
  endfunction

  // delay line, memory and stray-valid model; acts away from the active edge
  initial begin
    rd_valid = 1'b0; rd_word = '0; cyc = 0; pending = 0; armed = 0;
    mtap = 0; nread = 0; lcnt = 0; last_pulse = 0;
    rst_seen = 0; inc_seen = 0; req_seen = 0; gap_seen = 0; gap_bad = 0;
    forever begin
      @(negedge clk);
      cyc++;
      rd_valid = 1'b0;
      if (!rst_n) begin
        pending = 0;
      end else begin
        if (dly_rst) begin mtap = 0; nread = 0; rst_seen++; last_pulse = cyc; armed = 1; end
        if (dly_inc) begin mtap++; nread = 0; inc_seen++; last_pulse = cyc; armed = 1; end
        if (rd_req) begin
          req_seen++;
          if (armed) begin
            gap_seen++;
            if (cyc - last_pulse != SC + 1) gap_bad++;
            armed = 0;
          end
          pending = 1; lcnt = lat_g;
        end else if (pending) begin
          lcnt--;
          if (lcnt == 0) begin
            rd_valid = 1'b1;
            rd_word  = good_rd(mtap, nread, lo_g, hi_g, gl_g) ? TW_WORD : bad_word(kind_g);
            nread++;
            pending = 0;
          end
        end else if (spur_g) begin
          rd_valid = 1'b1;   // stray valid with a matching word: must be ignored (R4)
          rd_word  = TW_WORD;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic predict(input int lo, input int hi, input bit gl,
                         output bit ok, output int ftap, output int reads);
    ok = 0; reads = 0; ftap = NT - 1;
    for (int t = 0; t < NT; t++) begin
      int run = 0;
      int idx = 0;
      bit moved = 0;
      while (!moved) begin
        reads++;
        if (good_rd(t, idx, lo, hi, gl)) begin
          run++; idx++;
          if (run == PR) begin ok = 1; ftap = t; return; end
        end else begin
          moved = 1;
        end
      end
    end
  endtask

  task automatic run_scn(input int lo, input int hi, input bit gl, input int lat,
                         input int kind, input bit spur, input bit mid_start);
    bit exp_ok; int exp_tap; int exp_reads; int wait_n; int inc_hold; int req_hold; int tap_hold;
    bit hold_ok;
    predict(lo, hi, gl, exp_ok, exp_tap, exp_reads);
    lo_g = lo; hi_g = hi; gl_g = gl; lat_g = lat; kind_g = kind; spur_g = spur;
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    rst_seen = 0; inc_seen = 0; req_seen = 0; gap_seen = 0; gap_bad = 0;
    // R2: start clears status and issues the delay reset
    chk(!done && !fail && dly_rst, "R2 status cleared and delay reset", {done, fail, dly_rst}, 1);
    if (mid_start) begin
      repeat (6) @(posedge clk);
      #1;
      if (!done && !fail) begin
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
      end
    end
    wait_n = 0;
    while (!done && !fail && wait_n < 2000) begin
      @(posedge clk); #1; wait_n++;
    end
    // R7 / R8 outcome
    chk(done == exp_ok && fail == !exp_ok, exp_ok ? "R7 done" : "R8 fail", {done, fail}, exp_ok ? 2 : 1);
    // R7 / R8 final tap, R5 word-level judgement drives it
    chk(int'(tap) == exp_tap, "R5 R7 final tap", tap, exp_tap);
    // R6 / R8 one increment per stepped tap
    chk(inc_seen == exp_tap, "R6 R8 increment count", inc_seen, exp_tap);
    // R4 one request per read taken
    chk(req_seen == exp_reads, "R4 read count", req_seen, exp_reads);
    // R3 settle gap before each read following a pulse
    chk(gap_bad == 0 && gap_seen == exp_tap + 1, "R3 settle gap", gap_seen - gap_bad, exp_tap + 1);
    // R2 single reset pulse, mid-search start ignored
    chk(rst_seen == 1, "R2 reset pulse count", rst_seen, 1);
    inc_hold = inc_seen; req_hold = req_seen; tap_hold = int'(tap); hold_ok = 1;
    repeat (12) begin
      @(posedge clk); #1;
      if (done != exp_ok || fail != !exp_ok || int'(tap) != tap_hold) hold_ok = 0;
    end
    // R9 sticky status with quiet delay controls
    chk(hold_ok && inc_seen == inc_hold && req_seen == req_hold && rst_seen == 1,
        "R9 hold after finish", inc_seen - inc_hold + req_seen - req_hold, 0);
  endtask

  initial begin
    start = 1'b0; rst_n = 1'b0;
    lo_g = NT; hi_g = 0; gl_g = 0; lat_g = 1; kind_g = 0; spur_g = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk(dly_rst && !dly_inc && !rd_req && !done && !fail && tap == '0,
        "R1 reset state", {dly_rst, dly_inc, rd_req, done, fail}, 16);
    for (int lo = 0; lo <= NT; lo++) begin
      for (int wi = 0; wi < 3; wi++) begin
        for (int g = 0; g < 2; g++) begin
          int w;
          w = (wi == 0) ? 0 : (wi == 1) ? 1 : 3;
          run_scn(lo, lo + w, bit'(g), 1 + (lo + w) % 3, (lo + w + g) % 3,
                  bit'(g ^ (lo % 2)), wi == 1);
        end
      end
    end
    finish_run();
  end

endmodule